// File: doc/BRIEF.md
# Receive FIFO Periodic Flush Timer

This block counts macroticks and raises the FIFO almost-full interrupt request when received frames have been waiting too long in a FIFO that is not empty but has not reached its almost-full watermark. It keeps frames from staying in the receive FIFO when traffic is too light to ever cross the watermark.

A 14-bit duration setting selects the behaviour. Two codes are reserved. The value zero makes the timer permanently expired. The all-ones value 0x3FFF makes it never expire. Any other value N makes the timer restart at every communication cycle start. In that mode it expires after N macroticks, then restarts. Each expiry becomes an interrupt request when the enable input is high and the fill level lies strictly between zero and the watermark.

Top module: `rff_flush_timer`

## Requirements
- R1: Between reset and the first expiry, both `expired_o` and `irq_o` are low whenever the duration is not zero.
- R2: With a duration of 0x0000, `expired_o` is high on every clock.
- R3: With a duration of 0x3FFF, `expired_o` stays low whatever the macrotick and cycle-start inputs do. The count is held at zero, so a later switch to a duration N needs N fresh macroticks before it expires.
- R4: With a duration N in 1..0x3FFE, `expired_o` is high for exactly the one clock after the edge at which the N-th macrotick since the last restart is taken.
- R5: A cycle-start pulse reloads the count to zero. If it arrives in the same clock as a macrotick, it wins: that clock produces no expiry and the macrotick is not counted.
- R6: The count advances only on clocks with a macrotick pulse. Clocks without one leave the progress toward expiry unchanged.
- R7: If the duration is lowered to a value at or below the macroticks already counted, the next macrotick causes an expiry.
- R8: `irq_o` is high exactly when `expired_o` is high, `irq_en_i` is high, and 0 < `fill_lvl_i` < `watermark_i` (unsigned). In the zero-duration mode it therefore stays high for as long as those conditions hold.
- R9: `irq_o` is low when the fill level is zero, when the fill level is at or above the watermark, or when `irq_en_i` is low.
- R10: After an expiry the count restarts from zero, so with no cycle start in between, the next expiry needs another N macroticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mt_tick_i | input | 1 | One-clock macrotick pulse |
| cyc_start_i | input | 1 | One-clock communication cycle start pulse |
| dur_i | input | DUR_W (14) | Timer duration in macroticks; 0 and all-ones are reserved codes |
| fill_lvl_i | input | FILL_W (8) | Current FIFO fill level |
| watermark_i | input | FILL_W (8) | Almost-full watermark |
| irq_en_i | input | 1 | Enable for the interrupt request |
| expired_o | output | 1 | Timer expired indication |
| irq_o | output | 1 | Almost-full interrupt request |

## Verification
The assertions assume that macrotick and cycle-start pulses are synchronous to `clk` and sampled as levels on each edge. They also assume that the duration, fill level and watermark are stable around the clock edge. The bench drives every input on the falling edge and samples on the next falling edge, so each value is steady across exactly one rising edge. Duration changes are made only between steps, including the deliberate mid-count lowering and the switches into and out of the reserved codes.

// File: rtl/rff_timer_pkg.sv
package rff_timer_pkg;
  typedef enum logic [1:0] {
    TM_RUN    = 2'd0,
    TM_ALWAYS = 2'd1,
    TM_NEVER  = 2'd2
  } tmr_mode_e;
endpackage

// File: rtl/rff_mode_dec.sv
module rff_mode_dec
  import rff_timer_pkg::*;
#(
  parameter int DUR_W = 14
) (
  input  logic [DUR_W-1:0] dur_i,
  output tmr_mode_e        mode_o
);
  localparam logic [DUR_W-1:0] DurZero = '0;
  localparam logic [DUR_W-1:0] DurOnes = '1;

  always_comb begin
    if (dur_i == DurZero) begin
      mode_o = TM_ALWAYS;
    end else if (dur_i == DurOnes) begin
      mode_o = TM_NEVER;
    end else begin
      mode_o = TM_RUN;
    end
  end
endmodule

// File: rtl/rff_tick_cnt.sv
module rff_tick_cnt
  import rff_timer_pkg::*;
#(
  parameter int DUR_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             tick_i,
  input  logic             cyc_i,
  output logic             exp_pulse_o
);
  localparam int CW = DUR_W + 1;

  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;
  logic             upd;
  logic [CW-1:0]    cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);

  // next-state process
  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (mode_i != TM_RUN) begin
      cnt_d = '0;
    end else if (cyc_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_inc >= {1'b0, dur_i}) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_inc[DUR_W-1:0];
      end
    end
  end

  assign upd = tick_i | cyc_i | exp_q | (mode_i != TM_RUN);

  // register process with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign exp_pulse_o = exp_q;

  p_never_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TM_NEVER) |=> (cnt_q == '0) && !exp_q);

  p_cyc_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_i |=> (cnt_q == '0) && !exp_q);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cyc_i && mode_i == TM_RUN) |=> $stable(cnt_q) && !exp_q);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> (cnt_q == '0));
endmodule

// File: rtl/rff_req_gate.sv
module rff_req_gate #(
  parameter int FILL_W = 8
) (
  input  logic              expired_i,
  input  logic              en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-1:0] wm_i,
  output logic              req_o
);
  logic not_empty, below_wm;

  always_comb begin
    not_empty = (fill_i != '0);
    below_wm  = (fill_i < wm_i);
    req_o     = expired_i & en_i & not_empty & below_wm;
  end
endmodule

// File: rtl/rff_flush_timer.sv
module rff_flush_timer
  import rff_timer_pkg::*;
#(
  parameter int DUR_W  = 14,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mt_tick_i,
  input  logic              cyc_start_i,
  input  logic [DUR_W-1:0]  dur_i,
  input  logic [FILL_W-1:0] fill_lvl_i,
  input  logic [FILL_W-1:0] watermark_i,
  input  logic              irq_en_i,
  output logic              expired_o,
  output logic              irq_o
);
  tmr_mode_e mode;
  logic      exp_pulse;

  rff_mode_dec #(.DUR_W(DUR_W)) dec_i (
    .dur_i  (dur_i),
    .mode_o (mode)
  );

  rff_tick_cnt #(.DUR_W(DUR_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .dur_i       (dur_i),
    .tick_i      (mt_tick_i),
    .cyc_i       (cyc_start_i),
    .exp_pulse_o (exp_pulse)
  );

  assign expired_o = (mode == TM_ALWAYS) | exp_pulse;

  rff_req_gate #(.FILL_W(FILL_W)) gate_i (
    .expired_i (expired_o),
    .en_i      (irq_en_i),
    .fill_i    (fill_lvl_i),
    .wm_i      (watermark_i),
    .req_o     (irq_o)
  );

  p_req_needs_exp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> expired_o && irq_en_i);

  p_req_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (fill_lvl_i != '0) && (fill_lvl_i < watermark_i));

  p_never_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dur_i == '1) && $past(dur_i == '1) |-> !expired_o);

  p_cyc_no_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start_i && dur_i != '0) |=> (!expired_o || dur_i == '0));
endmodule

// File: tb/rff_flush_timer_tb_top.sv
module rff_flush_timer_tb_top;
  localparam int DW = 14;
  localparam int FW = 8;
  localparam logic [DW-1:0] NEVER = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mt_tick = 1'b0, cyc_start = 1'b0, irq_en = 1'b0;
  logic [DW-1:0] dur = 14'd5;
  logic [FW-1:0] fill = '0, wm = '0;
  logic expired_o, irq_o;

  int nchk = 0, nerr = 0;
  int mc = 0;
  bit me = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rff_flush_timer #(.DUR_W(DW), .FILL_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mt_tick_i(mt_tick), .cyc_start_i(cyc_start),
    .dur_i(dur), .fill_lvl_i(fill), .watermark_i(wm), .irq_en_i(irq_en),
    .expired_o(expired_o), .irq_o(irq_o));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0b expected=%0b (dur=%0d fill=%0d wm=%0d en=%0b)",
               tag, what, act, exp, dur, fill, wm, irq_en);
    end
  endtask

  task automatic step(input logic tk, input logic cs, input string tag);
    logic ee, ei;
    mt_tick = tk;
    cyc_start = cs;
    @(posedge clk);
    if (dur == 0 || dur == NEVER) begin
      mc = 0; me = 1'b0;
    end else if (cs) begin
      mc = 0; me = 1'b0;
    end else if (tk) begin
      if (mc + 1 >= int'(dur)) begin mc = 0; me = 1'b1; end
      else begin mc = mc + 1; me = 1'b0; end
    end else begin
      me = 1'b0;
    end
    @(negedge clk);
    ee = (dur == 0) || me;
    ei = ee && irq_en && (fill != 0) && (fill < wm);
    chk(tag, "expired", expired_o, ee);
    chk(tag, "irq", irq_o, ei);
    mt_tick = 1'b0;
    cyc_start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int dl[6] = '{1, 2, 3, 4, 7, 12};
    repeat (3) @(negedge clk);
    fill = 8'd1; wm = 8'd4; irq_en = 1'b1;
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "expired", expired_o, 1'b0);
    chk("R1", "irq", irq_o, 1'b0);
    step(1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");

    // R4/R10: periodic expiry over durations and macrotick spacings
    foreach (dl[k]) begin
      for (int gap = 1; gap <= 3; gap++) begin
        dur = DW'(dl[k]);
        step(1'b0, 1'b1, "R4/R10");
        for (int i = 0; i < 3 * dl[k] * gap + 5; i++)
          step((i % gap) == 0, 1'b0, "R4/R10");
      end
    end

    // R5: cycle start at each phase, including coincident with completing tick
    dur = 14'd4;
    for (int ph = 0; ph < 4; ph++) begin
      step(1'b0, 1'b1, "R5");
      for (int i = 0; i < ph; i++) step(1'b1, 1'b0, "R5");
      step(1'b1, 1'b1, "R5");
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R5");
    end

    // R6: idle clocks keep progress
    dur = 14'd3;
    step(1'b0, 1'b1, "R6");
    step(1'b1, 1'b0, "R6");
    step(1'b1, 1'b0, "R6");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, "R6");
    step(1'b0, 1'b0, "R6");

    // R7: duration lowered below progress
    dur = 14'd12;
    step(1'b0, 1'b1, "R7");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R7");
    dur = 14'd3;
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");

    // R3: never-expiring code, then fresh count after leaving it
    dur = NEVER;
    for (int i = 0; i < 100; i++) step(1'b1, (i % 37) == 5, "R3");
    dur = 14'd2;
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "R3");

    // R2/R8/R9: zero-duration mode, exhaustive fill/watermark/enable grid
    dur = 14'd0;
    for (int f = 0; f < 6; f++)
      for (int w = 0; w < 6; w++)
        for (int e = 0; e < 2; e++) begin
          fill = FW'(f); wm = FW'(w); irq_en = e[0];
          step(f[0], 1'b0, "R2/R8/R9");
        end

    // R8/R9: running mode grid, expiry on every second tick
    dur = 14'd2;
    step(1'b0, 1'b1, "R8/R9");
    for (int f = 0; f < 5; f++)
      for (int w = 0; w < 5; w++)
        for (int e = 0; e < 2; e++) begin
          fill = FW'(f); wm = FW'(w); irq_en = e[0];
          step(1'b1, 1'b0, "R8/R9");
          step(1'b1, 1'b0, "R8/R9");
        end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule